// File: doc/BRIEF.md
# Dual-Modulus Swallow-Counter Clock Divider

This block divides a fast input clock by a programmable ratio N = 8·B + A. It is built the way a dual-modulus divider in a frequency synthesizer feedback path is built. A prescaler divides its input by either 8 or 9. A swallow counter holds the high modulus for the first A prescaler cycles of every output period. A main counter runs the period for B prescaler cycles in total. The result is 9·A + 8·(B − A) = 8·B + A input cycles per output pulse. The prescaler is modelled as a cycle-accurate counter on the same clock as the rest of the logic.

The two ratio words are sampled only at an output-period boundary, at reset, or while the divider is idle. A period therefore never mixes two settings. A setting with B below 3, or with B not greater than A, is illegal. While such a setting is held, an error flag is raised and the output stays low, and the block keeps sampling its inputs until a legal pair appears. A standby input stops the divider completely. When it is released, counting restarts from the start of a period.

Top module: `swallow_div`

## Requirements
- R1: With a legal setting held, consecutive `div_pulse` rising edges are exactly 8·B + A clock cycles apart. Within each period the prescaler divides by 9 for the first A prescaler cycles and by 8 for the rest.
- R2: `div_pulse` is high for exactly one clock cycle per output period.
- R3: After reset is released, the first `div_pulse` is high in the cycle that follows the N-th rising clock edge after release, where N = 8·B + A for the inputs sampled at reset.
- R4: With B = 178 and A = 6, the output period is exactly 1430 clock cycles.
- R5: With B less than 3, `cfg_err` is 1 and `div_pulse` stays 0.
- R6: With B less than or equal to A, including B equal to A, `cfg_err` is 1 and `div_pulse` stays 0.
- R7: While `cfg_err` is 1, the ratio inputs are sampled every cycle. A legal pair applied then clears `cfg_err` after one edge. The first pulse is high in the cycle after the (N+1)-th edge that follows the change.
- R8: A change of `a_in` or `b_in` in the middle of a period does not alter that period. The next period uses the new ratio.
- R9: While `stby` is 1, `div_pulse` is 0 and the counters are held at the start of a period. After release, the first pulse follows the N-th edge, as after reset.
- R10: During reset, `div_pulse` is 0. `cfg_err` reflects the legality of the inputs sampled at the reset edge.
- R11: With A = 0, the prescaler never uses the divide-by-9 mode and the period is 8·B cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| stby | input | 1 | Standby: 1 stops and clears the divider |
| a_in | input | AW | Swallow count A (number of divide-by-9 prescaler cycles) |
| b_in | input | BW | Main count B (total prescaler cycles per period) |
| div_pulse | output | 1 | One-cycle pulse per output period |
| cfg_err | output | 1 | 1 while the active setting is illegal |

## Verification
The hardest case to reach is a ratio change that lands part-way through a period. Its only visible effect is the length of the next gap between pulses, and that gap must still carry the old ratio. The stimulus first locks onto a pulse, then changes the ratio a few cycles later. It measures the gap that was already under way and then the gap that follows, and checks that the first is the old N and the second is the new N. Recovery from an illegal setting is the second awkward case, because it is timed from the first edge that samples the legal pair and not from a reset. The bench changes the inputs while the error flag is up and counts the edges from that point.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

    // low prescaler modulus; the high modulus is one more
    localparam int DMD_LO_MOD = 8;
    // smallest legal main count
    localparam int DMD_MIN_B  = 3;

    typedef enum logic {
        MOD_LOW  = 1'b0,
        MOD_HIGH = 1'b1
    } pmode_t;

    // swallow/main counter status seen by the rest of the divider
    typedef struct packed {
        pmode_t mode;  // prescaler modulus requested for the current prescaler cycle
        logic   last;  // current prescaler cycle is the final one of the period
    } swl_stat_t;

    // a ratio pair is illegal when B is too small or does not exceed A
    function automatic logic cfg_bad(input logic [31:0] a, input logic [31:0] b);
        return (b < 32'(DMD_MIN_B)) || (b <= a);
    endfunction

endpackage

// File: rtl/dmd_prescaler.sv
module dmd_prescaler
    import dmd_pkg::*;
#(
    parameter int PRE = DMD_LO_MOD
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic sel_hi,
    output logic tc
);
    localparam int CW = $clog2(PRE + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] top_val;

    // terminal count is PRE for the high modulus, PRE-1 for the low one
    always_comb top_val = sel_hi ? CW'(PRE) : CW'(PRE - 1);

    assign tc = (cnt == top_val);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tc) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dmd_swallow.sv
module dmd_swallow
    import dmd_pkg::*;
#(
    parameter int AW = 8,
    parameter int BW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] a_in,
    input  logic [BW-1:0] b_in,
    input  logic          tc,
    output swl_stat_t     st
);
    logic [AW-1:0] a_left;
    logic [BW-1:0] b_left;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            a_left <= a_in;
            b_left <= b_in;
        end else if (tc) begin
            b_left <= b_left - 1'b1;
            if (a_left != '0) begin
                a_left <= a_left - 1'b1;
            end
        end
    end

    always_comb begin
        st.mode = (a_left != '0) ? MOD_HIGH : MOD_LOW;
        st.last = (b_left == BW'(1));
    end
endmodule

// File: rtl/dmd_cfg_hold.sv
module dmd_cfg_hold #(
    parameter int AW = 8,
    parameter int BW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] a_in,
    input  logic [BW-1:0] b_in,
    output logic [AW-1:0] a_act,
    output logic [BW-1:0] b_act
);
    // active ratio pair, changed only where a period starts
    always_ff @(posedge clk) begin
        if (rst || load) begin
            a_act <= a_in;
            b_act <= b_in;
        end
    end
endmodule

// File: rtl/swallow_div.sv
module swallow_div
    import dmd_pkg::*;
#(
    parameter int AW  = 8,
    parameter int BW  = 10,
    parameter int PRE = DMD_LO_MOD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stby,
    input  logic [AW-1:0] a_in,
    input  logic [BW-1:0] b_in,
    output logic          div_pulse,
    output logic          cfg_err
);
    logic          tc;
    logic          boundary;
    logic          hold;
    logic          load;
    logic          bad;
    logic          sel_hi;
    logic          pulse_q;
    swl_stat_t     st;
    logic [AW-1:0] a_act;
    logic [BW-1:0] b_act;

    // legality of the active pair, not of the live inputs
    assign bad      = cfg_bad(32'(a_act), 32'(b_act));
    assign hold     = stby | bad;
    assign boundary = tc & st.last;
    assign load     = hold | boundary;
    assign sel_hi   = (st.mode == MOD_HIGH);

    dmd_prescaler #(.PRE(PRE)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (hold),
        .sel_hi (sel_hi),
        .tc     (tc)
    );

    dmd_swallow #(.AW(AW), .BW(BW)) u_swl (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .a_in (a_in),
        .b_in (b_in),
        .tc   (tc),
        .st   (st)
    );

    dmd_cfg_hold #(.AW(AW), .BW(BW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .a_in  (a_in),
        .b_in  (b_in),
        .a_act (a_act),
        .b_act (b_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= boundary & ~hold;
        end
    end

    assign div_pulse = pulse_q & ~hold;
    assign cfg_err   = bad;
endmodule

// File: rtl/dmd_div_chk.sv
module dmd_div_chk #(
    parameter int AW  = 8,
    parameter int BW  = 10,
    parameter int PRE = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          stby,
    input logic [AW-1:0] a_in,
    input logic [BW-1:0] b_in,
    input logic          load,
    input logic          boundary,
    input logic          hold,
    input logic          sel_hi,
    input logic [AW-1:0] a_act,
    input logic [BW-1:0] b_act,
    input logic          div_pulse,
    input logic          cfg_err
);
    logic [31:0] since_load;
    logic [31:0] n_exp;

    // cycles elapsed since the last sampling of the ratio, and the ratio sampled
    always_ff @(posedge clk) begin
        if (rst || load) begin
            since_load <= '0;
            n_exp      <= 32'(PRE) * 32'(b_in) + 32'(a_in);
        end else begin
            since_load <= since_load + 1;
        end
    end

    // R1: a period ends exactly 8B+A cycles after it started
    p_period_len_r1: assert property (@(posedge clk) disable iff (rst)
        (boundary && !hold) |-> (since_load == n_exp - 1));

    // R1: once the high modulus is dropped it stays dropped until the period restarts
    p_nine_first_r1: assert property (@(posedge clk) disable iff (rst)
        (!sel_hi && !load) |=> !sel_hi);

    // R2: the output pulse never lasts two cycles
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R9: no pulse in the cycle after standby was high
    p_stby_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $past(stby) |-> !div_pulse);

    // R7: while in error, the inputs are taken in on the next edge
    p_err_sample_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> (a_act == $past(a_in)) && (b_act == $past(b_in)));

    // R8: the active ratio changes only at a load point
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(a_act) && $stable(b_act)));
endmodule

bind swallow_div dmd_div_chk #(.AW(AW), .BW(BW), .PRE(PRE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stby      (stby),
    .a_in      (a_in),
    .b_in      (b_in),
    .load      (load),
    .boundary  (boundary),
    .hold      (hold),
    .sel_hi    (sel_hi),
    .a_act     (a_act),
    .b_act     (b_act),
    .div_pulse (div_pulse),
    .cfg_err   (cfg_err)
);

// File: tb/swallow_div_tb.sv
module swallow_div_tb;
    localparam int AW  = 8;
    localparam int BW  = 10;
    localparam int NV  = 7;
    localparam int WDOG = 100000;

    // stimulus table: A, B and the expected period
    localparam int VA[NV] = '{0, 2, 7, 6,    0,  9, 8};
    localparam int VB[NV] = '{3, 3, 9, 178, 10, 10, 20};
    localparam int VN[NV] = '{24, 26, 79, 1430, 80, 89, 168};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stby = 1'b0;
    logic [AW-1:0] a_in = '0;
    logic [BW-1:0] b_in = 10'd3;
    logic          div_pulse;
    logic          cfg_err;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    swallow_div #(.AW(AW), .BW(BW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .stby      (stby),
        .a_in      (a_in),
        .b_in      (b_in),
        .div_pulse (div_pulse),
        .cfg_err   (cfg_err)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
        end
    endtask

    function automatic int bad_pair(input int a, input int b);
        return ((b < 3) || (b <= a)) ? 1 : 0;
    endfunction

    // R10: apply reset with a given pair and check the reset state
    task automatic do_reset(input int a, input int b);
        @(negedge clk);
        a_in = AW'(a);
        b_in = BW'(b);
        rst  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(div_pulse == 1'b0, "R10 pulse in reset", int'(div_pulse), 0);
        check(int'(cfg_err) == bad_pair(a, b), "R10 error flag in reset", int'(cfg_err), bad_pair(a, b));
        rst = 1'b0;
    endtask

    // count falling edges until the pulse is seen (limit+1 when never seen)
    task automatic wait_pulse(input int limit, output int cnt);
        cnt = 0;
        forever begin
            @(negedge clk);
            cnt = cnt + 1;
            if (div_pulse) break;
            if (cnt > limit) break;
        end
    endtask

    task automatic count_pulses(input int span, output int seen);
        seen = 0;
        for (int k = 0; k < span; k++) begin
            @(negedge clk);
            if (div_pulse) seen = seen + 1;
        end
    endtask

    initial begin
        int c;
        int c2;
        string tag;

        // table walk: first pulse timing, width, and steady period
        for (int i = 0; i < NV; i++) begin
            do_reset(VA[i], VB[i]);
            check(cfg_err == 1'b0, "R1 legal pair flagged", int'(cfg_err), 0);
            wait_pulse(3 * VN[i], c);
            check(c == VN[i], "R3 first pulse", c, VN[i]);
            @(negedge clk);
            check(div_pulse == 1'b0, "R2 pulse width", int'(div_pulse), 0);
            wait_pulse(3 * VN[i], c);
            if (VN[i] == 1430)   tag = "R4 period 178/6";
            else if (VA[i] == 0) tag = "R11 period with A=0";
            else                 tag = "R1 period";
            check(c + 1 == VN[i], tag, c + 1, VN[i]);
        end

        // R5: B below the minimum
        do_reset(0, 2);
        check(cfg_err == 1'b1, "R5 error flag B=2", int'(cfg_err), 1);
        count_pulses(300, c);
        check(c == 0, "R5 pulses with B=2", c, 0);
        do_reset(0, 0);
        count_pulses(100, c);
        check(c == 0 && cfg_err == 1'b1, "R5 pulses with B=0", c, 0);

        // R6: B not above A
        do_reset(6, 5);
        check(cfg_err == 1'b1, "R6 error flag B<A", int'(cfg_err), 1);
        do_reset(5, 5);
        check(cfg_err == 1'b1, "R6 error flag B=A", int'(cfg_err), 1);
        count_pulses(300, c);
        check(c == 0, "R6 pulses with B=A", c, 0);

        // R7: recovery from the error state without reset, N = 25
        @(negedge clk);
        a_in = AW'(1);
        b_in = BW'(3);
        @(negedge clk);
        check(cfg_err == 1'b0, "R7 error cleared", int'(cfg_err), 1'b0);
        wait_pulse(100, c);
        check(c == 25, "R7 first pulse after recovery", c + 1, 26);

        // R8: change in the middle of a period, 26 then 41
        do_reset(2, 3);
        wait_pulse(100, c);
        repeat (5) @(negedge clk);
        a_in = AW'(1);
        b_in = BW'(5);
        wait_pulse(100, c);
        check(c + 5 == 26, "R8 period under way keeps old ratio", c + 5, 26);
        wait_pulse(100, c2);
        check(c2 == 41, "R8 next period uses new ratio", c2, 41);

        // R9: standby silences and restarts the divider, N = 24
        do_reset(0, 3);
        wait_pulse(100, c);
        repeat (3) @(negedge clk);
        stby = 1'b1;
        count_pulses(100, c);
        check(c == 0, "R9 pulses in standby", c, 0);
        stby = 1'b0;
        wait_pulse(100, c);
        check(c == 24, "R9 first pulse after standby", c, 24);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule